// File: doc/BRIEF.md
# Access-Density Cache Replacement Controller

This block decides which line of one set of a write-back cache gives way when a fill needs space. Each line carries a weighted access-density score. A hit or a fill to a line adds one weight for a write and a different weight for a read. Every N retired instructions, all scores in the set are halved together, so old activity fades. When the cache asks for a victim, the block returns the line with the least density. Lines rarely touched leave first, and heavily written lines stay resident. Writes to a resident line therefore reach backing memory only when that line is finally evicted while dirty.

The surrounding cache controller does the tag lookup and holds the data. It reports each access with a line index, a read/write flag and a fill flag. It pulses the retire input once per retired instruction. It raises a one-cycle victim request on a miss. The block answers one cycle later with a victim index and a valid strobe. It also exports a dirty flag per line, so the controller knows whether the chosen victim needs a write-back.

Top module: `acd_repl_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every line's score, valid bit and dirty bit, the victim-valid output and the retire counter; during and right after reset, `vic_valid` is 0 and `line_dirty` is all zeros.
- R2: An access with `acc_fill`=1 marks line `acc_way` valid and sets its score to the weight of that access (`WR_WEIGHT` when `acc_write`=1, else `RD_WEIGHT`), replacing any earlier score; its dirty bit becomes `acc_write`.
- R3: An access with `acc_fill`=0 to a valid line adds the access weight to its score; a write sets its dirty bit, a read leaves the dirty bit unchanged. Without an access, dirty bits hold.
- R4: A score saturates at 2^`SCORE_W`-1 and never wraps past it.
- R5: The block counts `retire` pulses only, not idle cycles; on every `DECAY_N`-th pulse after reset, all scores are replaced by their floor half in the same clock edge.
- R6: When a decay and a hit to a line land in the same cycle, the line's new score is (old score / 2, rounded down) + access weight.
- R7: If any line is invalid, the victim is the invalid line with the lowest index.
- R8: If all lines are valid, the victim is the line with the smallest score; on a tie the lowest index wins.
- R9: `vic_valid` is 1 exactly in the cycle after `vic_req` was 1. `vic_way` then gives the victim for the state held in the request cycle, before any access in that same cycle takes effect.
- R10: An access with `acc_fill`=0 to an invalid line changes nothing: the line stays invalid and clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to a line takes place this cycle |
| acc_fill | input | 1 | The access installs a new line (1) or hits a resident one (0) |
| acc_write | input | 1 | The access is a write (1) or a read (0) |
| acc_way | input | $clog2(WAYS) | Line index of the access |
| retire | input | 1 | One pulse per retired instruction |
| vic_req | input | 1 | Victim request |
| vic_way | output | $clog2(WAYS) | Chosen victim line, held until the next request |
| vic_valid | output | 1 | Victim answer strobe, one cycle after the request |
| line_dirty | output | WAYS | Dirty flag of each line |

## Verification
The bench builds the block with 4 ways, 6-bit scores, a write weight of 3, a read weight of 1 and a decay interval of 5 pulses. With these values a line saturates after about twenty writes, a decay comes every few cycles, and ties between lines appear often, so both the saturation path and the tie rule are reached quickly. Directed sequences set up the orderings that only a correct halving, a correct decay-then-add order or a correct lowest-index rule can resolve. A long pseudo-random run then checks each victim answer and the dirty flags against scores that the bench computes arithmetically.

// File: rtl/acd_pkg.sv
package acd_pkg;

    // What a single line does in a given cycle.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2
    } lane_op_e;

endpackage

// File: rtl/acd_decay_timer.sv
module acd_decay_timer #(
    parameter int CNT_W   = 21,
    parameter int DECAY_N = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic retire,
    output logic tick
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DECAY_N - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = retire && (st_q.cnt == LAST);
        if (retire) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/acd_score_lane.sv
module acd_score_lane
    import acd_pkg::*;
#(
    parameter int SCORE_W   = 16,
    parameter int WR_WEIGHT = 4,
    parameter int RD_WEIGHT = 1
) (
    input  lane_op_e           op,
    input  logic               is_write,
    input  logic               halve,
    input  logic [SCORE_W-1:0] score_q,
    input  logic               valid_q,
    input  logic               dirty_q,
    output logic [SCORE_W-1:0] score_d,
    output logic               valid_d,
    output logic               dirty_d
);

    localparam logic [SCORE_W:0]   WR_EXT = (SCORE_W + 1)'(WR_WEIGHT);
    localparam logic [SCORE_W:0]   RD_EXT = (SCORE_W + 1)'(RD_WEIGHT);
    localparam logic [SCORE_W-1:0] SMAX   = '1;

    logic [SCORE_W-1:0] base;
    logic [SCORE_W:0]   weight;
    logic [SCORE_W:0]   sum;
    logic [SCORE_W-1:0] bumped;
    logic [SCORE_W-1:0] fresh;

    always_comb begin
        base   = halve ? (score_q >> 1) : score_q;
        weight = is_write ? WR_EXT : RD_EXT;
        sum    = {1'b0, base} + weight;
        bumped = sum[SCORE_W] ? SMAX : sum[SCORE_W-1:0];
        fresh  = weight[SCORE_W] ? SMAX : weight[SCORE_W-1:0];

        score_d = base;
        valid_d = valid_q;
        dirty_d = dirty_q;
        unique case (op)
            OP_FILL: begin
                score_d = fresh;
                valid_d = 1'b1;
                dirty_d = is_write;
            end
            OP_HIT: begin
                if (valid_q) begin
                    score_d = bumped;
                    dirty_d = dirty_q | is_write;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acd_min_finder.sv
module acd_min_finder #(
    parameter int WAYS    = 8,
    parameter int SCORE_W = 16,
    parameter int IDX_W   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]              valid,
    input  logic [WAYS-1:0][SCORE_W-1:0] score,
    output logic [IDX_W-1:0]             idx
);

    // Key: an invalid line ranks as zero, below every valid line.
    localparam int KEY_W = SCORE_W + 1;

    logic [KEY_W-1:0] key      [WAYS];
    logic [KEY_W-1:0] best_key;

    for (genvar g = 0; g < WAYS; g++) begin : g_key
        assign key[g] = valid[g] ? {1'b1, score[g]} : '0;
    end

    always_comb begin
        idx      = '0;
        best_key = key[0];
        for (int i = 1; i < WAYS; i++) begin
            if (key[i] < best_key) begin
                best_key = key[i];
                idx      = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/acd_repl_ctrl.sv
module acd_repl_ctrl
    import acd_pkg::*;
#(
    parameter int WAYS      = 8,
    parameter int SCORE_W   = 16,
    parameter int WR_WEIGHT = 4,
    parameter int RD_WEIGHT = 1,
    parameter int CNT_W     = 21,
    parameter int DECAY_N   = 200000,
    localparam int IDX_W    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] acc_way,
    input  logic             retire,
    input  logic             vic_req,
    output logic [IDX_W-1:0] vic_way,
    output logic             vic_valid,
    output logic [WAYS-1:0]  line_dirty
);

    typedef struct packed {
        logic [WAYS-1:0][SCORE_W-1:0] score;
        logic [WAYS-1:0]              valid;
        logic [WAYS-1:0]              dirty;
        logic [IDX_W-1:0]             vic_way;
        logic                         vic_valid;
    } state_t;

    state_t st_d, st_q;

    logic                         decay_tick;
    lane_op_e                     lane_op    [WAYS];
    logic [WAYS-1:0][SCORE_W-1:0] lane_score;
    logic [WAYS-1:0]              lane_valid;
    logic [WAYS-1:0]              lane_dirty;
    logic [IDX_W-1:0]             min_idx;
    logic [WAYS-1:0]              line_valid;
    logic [WAYS-1:0][SCORE_W-1:0] line_score;

    acd_decay_timer #(
        .CNT_W  (CNT_W),
        .DECAY_N(DECAY_N)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .retire(retire),
        .tick  (decay_tick)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_lane
        assign lane_op[g] = (acc_valid && (acc_way == IDX_W'(g)))
                          ? (acc_fill ? OP_FILL : OP_HIT) : OP_NONE;

        acd_score_lane #(
            .SCORE_W  (SCORE_W),
            .WR_WEIGHT(WR_WEIGHT),
            .RD_WEIGHT(RD_WEIGHT)
        ) lane_i (
            .op      (lane_op[g]),
            .is_write(acc_write),
            .halve   (decay_tick),
            .score_q (st_q.score[g]),
            .valid_q (st_q.valid[g]),
            .dirty_q (st_q.dirty[g]),
            .score_d (lane_score[g]),
            .valid_d (lane_valid[g]),
            .dirty_d (lane_dirty[g])
        );
    end

    acd_min_finder #(
        .WAYS   (WAYS),
        .SCORE_W(SCORE_W),
        .IDX_W  (IDX_W)
    ) finder_i (
        .valid(st_q.valid),
        .score(st_q.score),
        .idx  (min_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.score     = lane_score;
        st_d.valid     = lane_valid;
        st_d.dirty     = lane_dirty;
        st_d.vic_valid = vic_req;
        if (vic_req) begin
            st_d.vic_way = min_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vic_way    = st_q.vic_way;
    assign vic_valid  = st_q.vic_valid;
    assign line_dirty = st_q.dirty;
    assign line_valid = st_q.valid;
    assign line_score = st_q.score;

endmodule

// File: rtl/acd_repl_chk.sv
module acd_repl_chk #(
    parameter int WAYS    = 8,
    parameter int SCORE_W = 16,
    parameter int IDX_W   = $clog2(WAYS)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         acc_valid,
    input logic                         acc_fill,
    input logic                         acc_write,
    input logic [IDX_W-1:0]             acc_way,
    input logic                         retire,
    input logic                         vic_req,
    input logic [IDX_W-1:0]             vic_way,
    input logic                         vic_valid,
    input logic [WAYS-1:0]              line_dirty,
    input logic [WAYS-1:0]              valid_q,
    input logic [WAYS-1:0][SCORE_W-1:0] scores_q,
    input logic                         decay_tick
);

    logic [WAYS-1:0] prev_valid;

    always_ff @(posedge clk) begin
        prev_valid <= valid_q;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!vic_valid && (line_dirty == '0) && (valid_q == '0)));

    // R2
    fill_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_fill) |=> (line_dirty[$past(acc_way)] == $past(acc_write)));

    // R2
    fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_fill) |=> valid_q[$past(acc_way)]);

    // R3
    idle_dirty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (line_dirty == $past(line_dirty)));

    // R5
    tick_needs_retire_chk: assert property (@(posedge clk) disable iff (rst)
        decay_tick |-> retire);

    // R9
    vic_follow_chk: assert property (@(posedge clk) disable iff (rst)
        vic_req |=> vic_valid);

    // R9
    vic_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vic_req |=> !vic_valid);

    // R7
    invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && !(&prev_valid)) |-> !prev_valid[vic_way]);

    for (genvar g = 0; g < WAYS; g++) begin : g_wrap
        // R4
        no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            (acc_valid && !acc_fill && (acc_way == IDX_W'(g)) && valid_q[g] && !decay_tick)
            |=> (scores_q[g] >= $past(scores_q[g])));
    end

endmodule

bind acd_repl_ctrl acd_repl_chk #(
    .WAYS   (WAYS),
    .SCORE_W(SCORE_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_fill  (acc_fill),
    .acc_write (acc_write),
    .acc_way   (acc_way),
    .retire    (retire),
    .vic_req   (vic_req),
    .vic_way   (vic_way),
    .vic_valid (vic_valid),
    .line_dirty(line_dirty),
    .valid_q   (line_valid),
    .scores_q  (line_score),
    .decay_tick(decay_tick)
);

// File: tb/acd_repl_ctrl_tb.sv
module acd_repl_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS       = 4;
    localparam int SCORE_W    = 6;
    localparam int WR_W       = 3;
    localparam int RD_W       = 1;
    localparam int DECAY_N    = 5;
    localparam int IDX_W      = 2;
    localparam int SMAX       = 63;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             acc_valid = 1'b0;
    logic             acc_fill = 1'b0;
    logic             acc_write = 1'b0;
    logic [IDX_W-1:0] acc_way = '0;
    logic             retire = 1'b0;
    logic             vic_req = 1'b0;
    logic [IDX_W-1:0] vic_way;
    logic             vic_valid;
    logic [WAYS-1:0]  line_dirty;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int ms [WAYS];
    bit mv [WAYS];
    bit md [WAYS];
    int mcnt;

    acd_repl_ctrl #(
        .WAYS     (WAYS),
        .SCORE_W  (SCORE_W),
        .WR_WEIGHT(WR_W),
        .RD_WEIGHT(RD_W),
        .CNT_W    (21),
        .DECAY_N  (DECAY_N)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_fill  (acc_fill),
        .acc_write (acc_write),
        .acc_way   (acc_way),
        .retire    (retire),
        .vic_req   (vic_req),
        .vic_way   (vic_way),
        .vic_valid (vic_valid),
        .line_dirty(line_dirty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_dirty();
        int v = 0;
        for (int i = 0; i < WAYS; i++) v |= (int'(md[i]) << i);
        return v;
    endfunction

    function automatic int exp_victim();
        int best = 0;
        for (int i = 0; i < WAYS; i++) if (!mv[i]) return i;
        for (int i = 1; i < WAYS; i++) if (ms[i] < ms[best]) best = i;
        return best;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 0; acc_fill = 0; acc_write = 0;
        acc_way = '0; retire = 0; vic_req = 0;
        for (int i = 0; i < WAYS; i++) begin ms[i] = 0; mv[i] = 0; md[i] = 0; end
        mcnt = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(int'(vic_valid), 0, "R1", "vic_valid in reset");
        chk(int'(line_dirty), 0, "R1", "line_dirty in reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cyc(input bit av, input bit fl, input bit wr, input int w,
                       input bit rt, input bit rq, input string tag);
        int  ev;
        int  wt;
        bit  tick;
        @(negedge clk);
        acc_valid = av; acc_fill = fl; acc_write = wr;
        acc_way = IDX_W'(w); retire = rt; vic_req = rq;
        ev   = exp_victim();
        tick = rt && (mcnt == DECAY_N - 1);
        if (rt) mcnt = tick ? 0 : mcnt + 1;
        if (tick) for (int i = 0; i < WAYS; i++) ms[i] = ms[i] / 2;
        if (av) begin
            wt = wr ? WR_W : RD_W;
            if (fl) begin
                ms[w] = wt; mv[w] = 1'b1; md[w] = wr;
            end else if (mv[w]) begin
                ms[w] = ms[w] + wt;
                if (ms[w] > SMAX) ms[w] = SMAX;
                md[w] = md[w] | wr;
            end
        end
        @(posedge clk);
        #1;
        chk(int'(vic_valid), int'(rq), "R9", "vic_valid");
        if (rq) chk(int'(vic_way), ev, tag, "vic_way");
        chk(int'(line_dirty), model_dirty(), "R2 R3", "line_dirty");
    endtask

    task automatic idle_req(input string tag);
        cyc(0, 0, 0, 0, 0, 1, tag);
    endtask

    initial begin
        logic [15:0] lfsr;
        do_reset();

        // R1 R7: after reset every line is invalid, so way 0 is chosen
        idle_req("R7");

        // R2: fills with write and read weights
        cyc(1, 1, 1, 0, 0, 0, "R2");
        cyc(1, 1, 0, 1, 0, 0, "R2");
        cyc(1, 1, 0, 3, 0, 0, "R2");

        // R10: a hit to invalid way 2 leaves it invalid and clean
        cyc(1, 0, 1, 2, 0, 1, "R10");
        idle_req("R10");

        // R8: scores 3,1,1,1 -> tie resolved to way 1
        cyc(1, 1, 0, 2, 0, 0, "R2");
        idle_req("R8");
        // R3: read hit way 1 -> 2 ; scores 3,2,1,1 -> way 2
        cyc(1, 0, 0, 1, 0, 0, "R3");
        idle_req("R8");
        // R3: write hit way 2 -> 4, dirty ; scores 3,2,4,1 -> way 3
        cyc(1, 0, 1, 2, 0, 0, "R3");
        idle_req("R3");

        // R4: drive every way to saturation
        for (int k = 0; k < 25; k++) begin
            for (int w = 0; w < WAYS; w++) cyc(1, 0, 1, w, 0, 0, "R4");
        end
        idle_req("R4");
        cyc(1, 0, 0, 3, 0, 0, "R4");
        idle_req("R4");

        // R5: ways 0,1 at 3 and 2, ways 2,3 at 63
        cyc(1, 1, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, 0, "R3");
        cyc(1, 0, 0, 0, 0, 0, "R3");
        cyc(1, 1, 0, 1, 0, 0, "R2");
        cyc(1, 0, 0, 1, 0, 0, "R3");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 1, "R5");
        cyc(0, 0, 0, 0, 1, 1, "R5");
        idle_req("R5");

        // R6: way 0 at 2, way 1 at 3; decay and read hit on way 0 together
        cyc(1, 0, 0, 0, 0, 0, "R3");
        cyc(1, 0, 0, 1, 0, 0, "R3");
        cyc(1, 0, 0, 1, 0, 0, "R3");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, 1, "R6");
        cyc(1, 0, 0, 0, 1, 1, "R6");
        idle_req("R6");

        // Pseudo-random sweep against the arithmetic model
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < 8; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[1] & lfsr[2], lfsr[3], int'(lfsr[5:4]), lfsr[6], lfsr[7], "R8");
        end

        // Reset again mid-run
        do_reset();
        idle_req("R7");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule